// File: doc/BRIEF.md
# Serially Programmed Multichannel Pulse Delay

A bank of identical channels, each of which watches one trigger input for a rising edge and, after a programmable wait, produces an output pulse of fixed length. The wait is a fixed base offset plus a per-channel 4-bit step count multiplied by a step size. All timing is counted in ticks of a fast sampling clock. With the default parameters one tick stands for 2 ns, the base is 10 ticks, one step is 1 tick and the output pulse lasts 20 ticks. Once a channel has accepted an edge it ignores further edges until its output pulse has finished.

The step counts are written through a four-wire serial port plus an asynchronous clear. A bit is shifted into a shadow chain on each rising shift clock while the active-low select is held low. The shadow chain is copied into the working settings only when select is released. The last stage of the chain is driven onto a serial output, so several devices can be daisy-chained and the previous contents can be read back while new data is loaded. All serial port signals are synchronized into the sampling clock domain before use. Driving clear low at any time zeroes the chain and the settings and ends every pulse in progress.

Top module: `pulse_delay_bank`

## Requirements
- R1: A rising edge on `trig_in[c]` that is first sampled high at sampling edge 1 makes `pulse_out[c]` go high right after edge 3+BASE+N·STEP, where N is that channel's committed 4-bit step count.
- R2: Each output pulse is high for exactly WIDTH sampling cycles, whether the input stays high for 2 cycles or for longer than the whole delay plus pulse.
- R3: While select is low, each synchronized rising shift clock shifts `sdin` into a chain of NCH·4 bits. After a full load, the first bit sent is bit 3 of channel NCH-1 and the last bit sent is bit 0 of channel 0, so each channel's count is sent MSB first. Shift clock edges while select is high leave the chain unchanged.
- R4: The working settings change only when select rises (is released). Until then a channel keeps using its earlier count, even when a complete new load is already in the chain.
- R5: `sdout` is the last stage of the chain. Sending K new bits therefore returns, in order, the first K bits of the previous load, MSB first.
- R6: Clear low acts at once without a clock. It drives every `pulse_out` low, zeroes the chain (so `sdout` reads 0) and zeroes every channel's count, so the next delay is BASE.
- R7: A rising input edge that arrives while its channel is waiting or pulsing is ignored. Once the pulse has ended, the next edge is accepted normally.
- R8: Channels are independent: triggering one channel never raises the output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one tick per cycle |
| clr_n | input | 1 | Asynchronous active-low clear |
| sel_n | input | 1 | Active-low load select; its rising edge commits the chain |
| sclk | input | 1 | Serial shift clock, rising edge active |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Last chain stage, for daisy-chain and read-back |
| trig_in | input | NCH | Per-channel trigger inputs |
| pulse_out | output | NCH | Per-channel delayed output pulses |

## Verification
Every channel is programmed with the same count (0, 7 and 15 in turn), which separates the base offset from the step scaling. A ramp in which channel c gets count c shows whether the bit order and the channel mapping of the chain are right. The pattern read back on `sdout` during each load is compared with the previous load. A select held low over a full load tells the committed settings apart from the shadow chain. A long input pulse tells a fixed output width apart from one that follows the input, and repeated edges during a delay show that the dead time works. A clear in the middle of a pulse shows that clear acts at once and that the counts fall back to zero.

// File: rtl/pulse_delay_bank.sv
module pulse_delay_bank #(
  parameter int NCH    = 16,
  parameter int STEP_W = 4,
  parameter int BASE   = 10,
  parameter int STEP   = 1,
  parameter int WIDTH  = 20,
  parameter int SYNC   = 2
) (
  input  logic           clk,
  input  logic           clr_n,
  input  logic           sel_n,
  input  logic           sclk,
  input  logic           sdin,
  output logic           sdout,
  input  logic [NCH-1:0] trig_in,
  output logic [NCH-1:0] pulse_out
);
  localparam int NBITS = NCH * STEP_W;
  localparam int MAXN  = (1 << STEP_W) - 1;
  localparam int SPAN  = BASE + STEP * MAXN + WIDTH;
  localparam int CW    = $clog2(SPAN + 1);

  logic [SYNC-1:0]  sel_sr, sclk_sr, sdin_sr;
  logic             sel_s, sclk_s, sdin_s, sel_d, sclk_d;
  logic             shift_ev, commit_ev;
  logic [NBITS-1:0] chain, dly_q;

  assign sel_s  = sel_sr[SYNC-1];
  assign sclk_s = sclk_sr[SYNC-1];
  assign sdin_s = sdin_sr[SYNC-1];

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sel_sr  <= '1;
      sclk_sr <= '0;
      sdin_sr <= '0;
      sel_d   <= 1'b1;
      sclk_d  <= 1'b0;
    end else begin
      sel_sr  <= {sel_sr[SYNC-2:0], sel_n};
      sclk_sr <= {sclk_sr[SYNC-2:0], sclk};
      sdin_sr <= {sdin_sr[SYNC-2:0], sdin};
      sel_d   <= sel_s;
      sclk_d  <= sclk_s;
    end
  end

  assign shift_ev  = sclk_s & ~sclk_d & ~sel_s;
  assign commit_ev = sel_s & ~sel_d;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      chain <= '0;
      dly_q <= '0;
    end else begin
      if (shift_ev)  chain <= {chain[NBITS-2:0], sdin_s};
      if (commit_ev) dly_q <= chain;
    end
  end

  assign sdout = chain[NBITS-1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SYNC-1:0] tsr;
    logic            tprev, busy, start;
    logic [CW-1:0]   cnt, tgt, dly_c;

    assign dly_c = CW'(BASE) + CW'(STEP) * CW'(dly_q[c*STEP_W +: STEP_W]);
    assign start = tsr[SYNC-1] & ~tprev & ~busy;

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
        tsr   <= '0;
        tprev <= 1'b0;
        busy  <= 1'b0;
        cnt   <= '0;
        tgt   <= '0;
      end else begin
        tsr   <= {tsr[SYNC-2:0], trig_in[c]};
        tprev <= tsr[SYNC-1];
        if (busy) begin
          cnt <= cnt + CW'(1);
          if (cnt == tgt + CW'(WIDTH - 1)) busy <= 1'b0;
        end else if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          tgt  <= dly_c;
        end
      end
    end

    assign pulse_out[c] = busy & (cnt >= tgt);
  end
endmodule

// File: rtl/pulse_delay_bank_chk.sv
module pulse_delay_bank_chk #(
  parameter int NCH    = 16,
  parameter int STEP_W = 4,
  parameter int WIDTH  = 20
) (
  input logic                    clk,
  input logic                    clr_n,
  input logic                    sel_s,
  input logic                    shift_ev,
  input logic [NCH*STEP_W-1:0]   chain,
  input logic [NCH*STEP_W-1:0]   dly_q,
  input logic                    sdout,
  input logic [NCH-1:0]          pulse_out
);
  localparam int NBITS = NCH * STEP_W;
  localparam int RW    = $clog2(WIDTH + 2);

  for (genvar c = 0; c < NCH; c++) begin : g_run
    logic [RW-1:0] run;
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)            run <= '0;
      else if (pulse_out[c]) run <= run + RW'(1);
      else                   run <= '0;
    end

    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!clr_n)
      $fell(pulse_out[c]) |-> run == RW'(WIDTH));

    p_pulse_cap_r2: assert property (@(posedge clk) disable iff (!clr_n)
      run <= RW'(WIDTH));
  end

  p_commit_only_r4: assert property (@(posedge clk) disable iff (!clr_n)
    !$stable(dly_q) |-> ($past(sel_s) && !$past(sel_s, 2)));

  p_idle_chain_r3: assert property (@(posedge clk) disable iff (!clr_n)
    sel_s |=> $stable(chain));

  p_sdout_tail_r5: assert property (@(posedge clk) disable iff (!clr_n)
    shift_ev |=> sdout == $past(chain[NBITS-2]));

  p_clear_r6: assert property (@(posedge clk)
    !clr_n |-> (pulse_out == '0 && dly_q == '0 && chain == '0));
endmodule

bind pulse_delay_bank pulse_delay_bank_chk #(
  .NCH(NCH), .STEP_W(STEP_W), .WIDTH(WIDTH)
) u_chk (
  .clk(clk), .clr_n(clr_n), .sel_s(sel_s), .shift_ev(shift_ev),
  .chain(chain), .dly_q(dly_q), .sdout(sdout), .pulse_out(pulse_out)
);

// File: tb/pulse_delay_bank_test.sv
module pulse_delay_bank_test;
  localparam int NCH = 16, BASE = 10, STEP = 1, WIDTH = 20;

  logic clk = 1'b0;
  logic clr_n, sel_n, sclk, sdin;
  logic sdout;
  logic [NCH-1:0] trig;
  logic [NCH-1:0] pulse_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pulse_delay_bank uut (
    .clk(clk), .clr_n(clr_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
    .sdout(sdout), .trig_in(trig), .pulse_out(pulse_out)
  );

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] uni(input int n);
    logic [63:0] v;
    for (int c = 0; c < NCH; c++) v[4*c +: 4] = 4'(n);
    return v;
  endfunction

  function automatic logic [63:0] ramp();
    logic [63:0] v;
    for (int c = 0; c < NCH; c++) v[4*c +: 4] = 4'(c);
    return v;
  endfunction

  task automatic shift_bit(input logic b, output logic o);
    o = sdout;
    sdin = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic load(input logic [63:0] v, input bit release_sel,
                      input logic [63:0] prev, input string req);
    logic [63:0] rb;
    logic o;
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 63; i >= 0; i--) begin
      shift_bit(v[i], o);
      rb[i] = o;
    end
    check(rb == prev, req, "sdout read-back", rb, prev);
    if (release_sel) begin
      sel_n = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic fire(input int c, input int n, input int hold, input string req);
    int d = BASE + n * STEP;
    int rise = -1, fall = -1, last;
    bit other = 0;
    last = d + WIDTH + 8;
    if (hold + 2 > last) last = hold + 2;
    @(negedge clk);
    trig[c] = 1'b1;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (k == hold) trig[c] = 1'b0;
      if (pulse_out[c] && rise < 0) rise = k;
      if (!pulse_out[c] && rise >= 0 && fall < 0) fall = k;
      if ((pulse_out & ~(NCH'(1) << c)) != '0) other = 1;
    end
    trig[c] = 1'b0;
    check(rise == 3 + d, req, $sformatf("ch%0d rise tick", c), rise, 3 + d);
    check(fall - rise == WIDTH, "R2", $sformatf("ch%0d width", c), fall - rise, WIDTH);
    check(!other, "R8", $sformatf("ch%0d other outputs quiet", c), other, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    clr_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdin = 1'b0; trig = '0;
    repeat (5) @(negedge clk);
    check(pulse_out == '0, "R6", "outputs in clear", pulse_out, 0);
    check(sdout == 1'b0, "R6", "sdout in clear", sdout, 0);
    clr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_uniform();
    logic [63:0] prev = '0;
    int ns[3] = '{0, 7, 15};
    foreach (ns[i]) begin
      load(uni(ns[i]), 1, prev, "R5");
      prev = uni(ns[i]);
      for (int c = 0; c < NCH; c++) fire(c, ns[i], 2, "R1");
    end
  endtask

  task automatic t_ramp();
    load(ramp(), 1, uni(15), "R5");
    for (int c = 0; c < NCH; c++) fire(c, c, 2, "R3");
  endtask

  task automatic t_hold();
    load(uni(7), 1, ramp(), "R5");
    load(uni(15), 0, uni(7), "R5");
    fire(3, 7, 2, "R4");
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
    fire(3, 15, 2, "R4");
  endtask

  task automatic t_idle_sclk();
    sdin = 1'b0;
    for (int i = 0; i < 10; i++) begin
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    fire(0, 15, 2, "R3");
    load(uni(2), 1, uni(15), "R3");
  endtask

  task automatic t_long_input();
    fire(6, 2, 60, "R2");
  endtask

  task automatic t_dead_time();
    int d = BASE + 2 * STEP;
    int rise = -1, fall = -1, rises = 0;
    logic prev = 1'b0;
    @(negedge clk);
    trig[5] = 1'b1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (k == 2 || k == 8 || k == 22) trig[5] = 1'b0;
      if (k == 6 || k == 20) trig[5] = 1'b1;
      if (pulse_out[5] && !prev) rises++;
      if (pulse_out[5] && rise < 0) rise = k;
      if (!pulse_out[5] && rise >= 0 && fall < 0) fall = k;
      prev = pulse_out[5];
    end
    check(rises == 1, "R7", "pulses from retriggered input", rises, 1);
    check(rise == 3 + d, "R7", "rise with retrigger", rise, 3 + d);
    check(fall - rise == WIDTH, "R7", "width with retrigger", fall - rise, WIDTH);
    fire(5, 2, 2, "R7");
  endtask

  task automatic t_clear_mid();
    load(uni(15), 1, uni(2), "R5");
    @(negedge clk);
    trig[2] = 1'b1;
    repeat (2) @(negedge clk);
    trig[2] = 1'b0;
    repeat (30) @(negedge clk);
    check(pulse_out[2] == 1'b1, "R6", "pulse running before clear", pulse_out[2], 1);
    #1 clr_n = 1'b0;
    #1 check(pulse_out == '0, "R6", "outputs right after clear", pulse_out, 0);
    check(sdout == 1'b0, "R6", "sdout after clear", sdout, 0);
    @(negedge clk);
    clr_n = 1'b1;
    repeat (5) @(negedge clk);
    fire(2, 0, 2, "R6");
    load(uni(0), 1, '0, "R6");
  endtask

  initial begin
    t_reset();
    t_uniform();
    t_ramp();
    t_hold();
    t_idle_sclk();
    t_long_input();
    t_dead_time();
    t_clear_mid();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule